// File: doc/BRIEF.md
# Clause 45 Management Serial Master

This block is a register-mapped master for the two-wire station management bus. It generates the management clock (MDC) from the system clock and shifts indirect-access frames onto the bidirectional data line (MDIO). A register access takes two frames in sequence. The first is an address frame that carries the 16-bit register address. The second is a write frame or a read frame, sent to the same port and device.

Software packs one complete 32-bit frame into the frame word at word offset 0x11, with these fields:

| Bits | Field |
|------|-------|
| 31:30 | start code, 00 for indirect framing |
| 29:28 | opcode: 00 address, 01 write, 11 read |
| 27:23 | port |
| 22:18 | device |
| 17:16 | turnaround, written as 10 |
| 15:0 | payload |

Software then starts the frame through the control word at offset 0x10. It writes bit 3 as 0, then 1, then 0, and the transfer begins on the 0-to-1 step. It watches bit 0 of the status word at offset 0x14 until that bit clears. When a read frame completes, the 16 bits captured from the PHY replace the payload field of the frame word.

Each frame is sent as 32 preamble ones followed by the 32 frame bits, most significant bit first. The master updates MDIO only on a falling MDC edge and samples MDIO on a rising edge. MDC runs only while a frame is active. Each MDC half period lasts `HALF_CYCLES` system clocks.

Top module: `mdio_master`

## Requirements
- R1: After reset the status busy bit (0x14 bit 0) reads 0, MDC is low, MDIO output enable is low, and the frame word (0x11) reads 0.
- R2: The frame word at offset 0x11 reads back the full 32-bit value last written to it.
- R3: A write to 0x10 that moves control bit 3 from 0 to 1 while idle starts a frame, and status bit 0 reads 1 until the frame ends.
- R4: A frame is 32 ones followed by frame word bits 31 down to 0, one bit per MDC period, giving exactly 64 MDC rising edges.
- R5: MDIO output never changes while MDC is high. A new bit appears on the falling edge, and the input is sampled on the rising edge.
- R6: Each high phase of MDC lasts exactly `HALF_CYCLES` system clocks.
- R7: On a read frame (opcode 11) the output enable is low for the two turnaround bits and the 16 data bits. These are frame positions 17 down to 0, which are MDC periods 46 to 63.
- R8: On address frames (opcode 00) and write frames (opcode 01) the output enable stays high for all 64 bits, and the turnaround bits go out as written.
- R9: A 0-to-1 step of control bit 3 while busy is ignored. No second frame follows.
- R10: A write to the frame word during a frame does not change the bits being shifted, and the written value reads back afterward.
- R11: After a read frame, frame word bits 15:0 hold the 16 sampled bits, first received in bit 15, and bits 31:16 are kept. After any frame, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word offset of the register access |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe_o | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench records every bit on each MDC rising edge and compares the whole 64-bit train against the frame word. This exposes a master that drops preamble bits, sends the word LSB first, or places the turnaround at the wrong position. A read with a payload of all ones and a reply of 0x0001 catches capture that is off by one bit or that merges the reply with stale payload bits. A second start edge and a frame-word write issued mid-frame catch a master that restarts or that shifts from the live register rather than a shadow. High-phase lengths and MDIO changes during high phases are counted to expose divider or edge-alignment errors.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned DATA_BITS  = 16;
  localparam int unsigned TOTAL_BITS = PRE_BITS + FRAME_BITS;

  localparam logic [5:0] OFS_CTRL  = 6'h10;
  localparam logic [5:0] OFS_FRAME = 6'h11;
  localparam logic [5:0] OFS_STAT  = 6'h14;

  localparam int unsigned CTRL_GO_BIT = 3;
  localparam logic [1:0] OP_RD = 2'b11;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  prt;
    logic [4:0]  dev;
    logic [1:0]  ta;
    logic [15:0] payload;
  } mgmt_frame_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned HALF_CYCLES = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CNT_MAX);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_rise_raises_mdc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  mgmt_frame_t          frame_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 busy_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic                 cap_we_o,
  output logic [DATA_BITS-1:0] cap_o
);
  localparam int unsigned IW  = $clog2(TOTAL_BITS);
  localparam int unsigned FIW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL_BITS - 1);
  localparam logic [IW-1:0] PRE_END  = IW'(PRE_BITS);
  localparam logic [IW-1:0] TA_FIRST = IW'(PRE_BITS + FRAME_BITS - DATA_BITS - 2);
  localparam logic [IW-1:0] CAP_FIRST = IW'(TOTAL_BITS - DATA_BITS);

  logic                  busy_q, rd_q, mdio_q, oe_q;
  logic [IW-1:0]         idx_q, idx_nx, pos_nx;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [DATA_BITS-1:0]  cap_q;
  logic                  nxt_bit;

  // frame bit for MDC period n sits at word position TOTAL-1-n
  assign idx_nx  = idx_q + 1'b1;
  assign pos_nx  = LAST_IDX - idx_nx;
  assign nxt_bit = (idx_nx < PRE_END) ? 1'b1 : shreg_q[pos_nx[FIW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      mdio_q  <= 1'b0;
      oe_q    <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
      cap_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      rd_q    <= (frame_i.op == OP_RD);
      mdio_q  <= 1'b1;
      oe_q    <= 1'b1;
      idx_q   <= '0;
      shreg_q <= frame_i;
      cap_q   <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= CAP_FIRST))
        cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          mdio_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idx_q  <= idx_nx;
          mdio_q <= nxt_bit;
          oe_q   <= !(rd_q && (idx_nx >= TA_FIRST));
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign cap_o     = cap_q;
  assign cap_we_o  = busy_q && fall_i && rd_q && (idx_q == LAST_IDX);

  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(shreg_q));
  p_preamble_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q < PRE_END) |-> (mdio_q && oe_q));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  input  logic                 busy_i,
  input  logic                 cap_we_i,
  input  logic [DATA_BITS-1:0] cap_i,
  output logic                 start_o,
  output mgmt_frame_t          frame_o
);
  logic [3:0]  ctrl_q;
  mgmt_frame_t frame_q;
  logic        hit_ctrl, hit_frame, hit_stat;

  assign hit_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_frame = (addr_i == ADDR_W'(OFS_FRAME));
  assign hit_stat  = (addr_i == ADDR_W'(OFS_STAT));

  assign start_o = we_i && hit_ctrl && wdata_i[CTRL_GO_BIT]
                   && !ctrl_q[CTRL_GO_BIT] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      frame_q <= '0;
    end else begin
      if (we_i && hit_ctrl) ctrl_q <= wdata_i[3:0];
      if (we_i && hit_frame) frame_q <= wdata_i;
      // capture wins the payload field over a same-cycle bus write
      if (cap_we_i) frame_q.payload <= cap_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)  rdata_o = {{(WORD_W-4){1'b0}}, ctrl_q};
    if (hit_frame) rdata_o = frame_q;
    if (hit_stat)  rdata_o = {{(WORD_W-1){1'b0}}, busy_i};
  end

  assign frame_o = frame_q;

  p_start_sets_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_i);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 25,
  parameter int unsigned ADDR_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic                 busy, start, rise, fall, cap_we;
  logic [DATA_BITS-1:0] cap;
  mgmt_frame_t          frame;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy),
    .cap_we_i (cap_we),
    .cap_i    (cap),
    .start_o  (start),
    .frame_o  (frame)
  );

  mdio_clk_gen #(.HALF_CYCLES(HALF_CYCLES)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (frame),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .cap_we_o  (cap_we),
    .cap_o     (cap)
  );

  p_mdio_still_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 4;
  localparam int NVEC = 4;
  // {frame word, PHY reply}
  localparam logic [47:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 5'd3,  5'd5, 2'b10, 16'hA55A, 16'h0000},
    {2'b00, 2'b01, 5'd3,  5'd5, 2'b10, 16'h1234, 16'h0000},
    {2'b00, 2'b11, 5'd9,  5'd1, 2'b10, 16'h0000, 16'hBEEF},
    {2'b00, 2'b11, 5'd31, 5'd30, 2'b10, 16'hFFFF, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          rise_cnt = 0;
  logic [63:0] seen_bits, seen_oe;
  logic [15:0] cur_reply = '0;
  int          hi_cnt = 0;
  int          bad_hi = 0;
  int          hi_changes = 0;
  logic        prev_mdio = 1'b0;

  always #4 clk = !clk;

  mdio_master #(.HALF_CYCLES(HALF), .ADDR_W(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: reply bits for MDC periods 48..63, MSB first
  assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? cur_reply[63 - rise_cnt] : 1'b1;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      seen_bits[rise_cnt] = mdio_out;
      seen_oe[rise_cnt]   = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge clk) begin
    if (mdc) begin
      hi_cnt = hi_cnt + 1;
      if (mdio_out !== prev_mdio) hi_changes = hi_changes + 1;
    end else if (hi_cnt != 0) begin
      if (hi_cnt != HALF) bad_hi = bad_hi + 1;
      hi_cnt = 0;
    end
    prev_mdio = mdio_out;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h14, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] exp_bits(input logic [31:0] f);
    logic [63:0] e;
    for (int k = 0; k < 64; k++) e[k] = (k < 32) ? 1'b1 : f[63 - k];
    return e;
  endfunction

  function automatic logic [63:0] exp_oe(input logic [31:0] f);
    logic [63:0] e;
    for (int k = 0; k < 64; k++) e[k] = !((f[29:28] == 2'b11) && k >= 46);
    return e;
  endfunction

  function automatic logic [63:0] mask_bits(input logic [63:0] b, input logic [63:0] oe);
    return b & oe;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] fa, fb;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h14, r);
    chk("R1 busy", 64'(r[0]), 64'd0);
    chk("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(6'h11, r);
    chk("R1 frame", 64'(r), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] f;
      f = VEC[v][47:16];
      cur_reply = VEC[v][15:0];
      rise_cnt = 0; bad_hi = 0; hi_changes = 0;
      wr(6'h11, f);
      rd(6'h11, r);
      chk("R2 readback", 64'(r), 64'(f));
      wr(6'h10, 32'h5);
      wr(6'h10, 32'hD);
      rd(6'h14, r);
      chk("R3 busy set", 64'(r[0]), 64'd1);
      wr(6'h10, 32'h5);
      wait_idle();
      chk("R4 rise count", 64'(rise_cnt), 64'd64);
      chk("R4/R8 bits", mask_bits(seen_bits, exp_oe(f)), mask_bits(exp_bits(f), exp_oe(f)));
      chk("R7/R8 oe", seen_oe, exp_oe(f));
      chk("R5 hold", 64'(hi_changes), 64'd0);
      chk("R6 half", 64'(bad_hi), 64'd0);
      rd(6'h11, r);
      if (f[29:28] == 2'b11)
        chk("R11 capture", 64'(r), 64'({f[31:16], cur_reply}));
      else
        chk("R2 kept", 64'(r), 64'(f));
    end

    // R9/R10: second edge and frame rewrite mid-frame
    fa = {2'b00, 2'b01, 5'd31, 5'd31, 2'b10, 16'h00FF};
    fb = {2'b00, 2'b11, 5'd1, 5'd2, 2'b10, 16'hC3C3};
    cur_reply = '0;
    rise_cnt = 0;
    wr(6'h11, fa);
    wr(6'h10, 32'h5);
    wr(6'h10, 32'hD);
    repeat (100) @(negedge clk);
    wr(6'h11, fb);
    wr(6'h10, 32'h5);
    wr(6'h10, 32'hD);
    wait_idle();
    chk("R10 bits unchanged", seen_bits, exp_bits(fa));
    chk("R9 one frame", 64'(rise_cnt), 64'd64);
    repeat (40) @(negedge clk);
    rd(6'h14, r);
    chk("R9 no restart", 64'({r[0], 6'(rise_cnt)}), 64'({1'b0, 6'd0}));
    chk("R11 idle lines", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(6'h11, r);
    chk("R10 new value", 64'(r), 64'(fb));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule